// File: doc/BRIEF.md
# Reduced-Complexity Wallace Tree Multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product. It does not use a behavioural multiply. Every operand bit pair is combined by an AND gate into a partial-product bit of weight 2^(i+j). The bits are stacked per column from the bottom up, so the bit matrix has the shape of an inverted triangle.

The matrix is then compressed in successive stages. In each stage, the bit positions of a column are taken in groups of three:

- A group of three bits becomes one full adder. Its sum stays in the column and its carry moves up one weight.
- A group of two bits passes through untouched.
- A single bit passes through untouched.

A two-bit group gets a half adder only when passing it through would leave that column taller than the row count a conventional Wallace tree has after the same stage. Because of this, the number of stages never grows beyond the conventional figure.

Once every column holds at most two bits, the two rows go to an adder that looks ahead across 4-bit groups. A parameter chooses between a purely combinational product and one registered output stage. The register has a synchronous active-high reset.

Top module: `wtm_mult`

## Requirements
- R1: `prod` equals `op_a * op_b` as unsigned integers over all 2N bits, with no truncation, for N = 8.
- R2: With N = 4, `prod` is correct for all 256 operand pairs.
- R3: When either operand is zero, `prod` is zero.
- R4: When `op_a` is 1, `prod` equals `op_b` zero-extended to 2N bits.
- R5: All-ones times all-ones yields (2^N-1)^2, which is 65025 for N = 8 and 225 for N = 4.
- R6: With `OUT_REG` = 1, `prod` shows the product of the operands sampled at the previous rising edge. It holds that value until the next edge. While `rst` is high at an edge, `prod` becomes zero.
- R7: With `OUT_REG` = 0, `prod` follows the operands combinationally without any clock edge.
- R8: For single-bit operands 2^i and 2^j, `prod` is exactly 2^(i+j). This confirms the weight of every partial-product bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product, registered when `OUT_REG` = 1 |

## Verification
The assertions assume that the operands are fully known (no X or Z) at every sampled edge once reset is released. In the registered variant, they also assume that the operands seen at one edge are the ones whose product must appear at the next edge. The bench drives both operands together at the falling edge, so each value is settled and stable across the following rising edge. It never leaves an operand undriven. It also keeps reset asserted for the first edges, so the registered checks only begin after one clean capture.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

  // Plans the reduction for an n-bit multiplier.
  // what: 0 = height of column col entering stage stg
  //       1 = half adder used in column col at stage stg
  //       2 = number of stages, 3 = tallest column at any stage
  function automatic int wt_info(input int n, input int stg, input int col, input int what);
    int h [64];
    int nh [64];
    int w, rows, lim, s, mx, hmax, fa, rm, ha;
    if ((what < 2) && ((col < 0) || (col >= 2 * n))) return 0;
    w = 2 * n;
    for (int c = 0; c < 64; c++) begin
      h[c] = (c < n) ? c + 1 : ((c < w - 1) ? w - 1 - c : 0);
    end
    rows = n;
    hmax = n;
    s    = 0;
    for (int it = 0; it < 64; it++) begin
      mx = 0;
      for (int c = 0; c < w; c++) if (h[c] > mx) mx = h[c];
      if (mx <= 2) break;
      if ((what == 0) && (s == stg)) return h[col];
      rows = 2 * (rows / 3) + rows % 3;
      lim  = (rows < 2) ? 2 : rows;
      for (int c = 0; c < 64; c++) nh[c] = 0;
      for (int c = 0; c < w; c++) begin
        fa = h[c] / 3;
        rm = h[c] % 3;
        nh[c] += fa + rm;
        if (c + 1 < w) nh[c+1] += fa;
        ha = 0;
        if ((rm == 2) && (nh[c] > lim)) begin
          ha = 1;
          nh[c] -= 1;
          if (c + 1 < w) nh[c+1] += 1;
        end
        if ((what == 1) && (s == stg) && (c == col)) return ha;
      end
      for (int c = 0; c < 64; c++) begin
        h[c] = nh[c];
        if (h[c] > hmax) hmax = h[c];
      end
      s++;
    end
    case (what)
      0:       return h[col];
      2:       return s;
      3:       return hmax;
      default: return 0;
    endcase
  endfunction

  function automatic int wt_stages(input int n);
    return wt_info(n, 0, 0, 2);
  endfunction

  function automatic int wt_hmax(input int n);
    return wt_info(n, 0, 0, 3);
  endfunction

  // Bits lo..hi-1 of a 4-bit lookahead group.
  function automatic logic [3:0] grp_mask(input int lo, input int hi);
    logic [3:0] m;
    for (int k = 0; k < 4; k++) m[k] = (k >= lo) && (k < hi);
    return m;
  endfunction

endpackage

// File: rtl/wtm_ppgen.sv
module wtm_ppgen #(
  parameter int N    = 8,
  parameter int W    = 2 * N,
  parameter int HMAX = N
) (
  input  logic [N-1:0]              op_a,
  input  logic [N-1:0]              op_b,
  output logic [W-1:0][HMAX-1:0]    cols
);

  for (genvar c = 0; c < W; c++) begin : g_col
    localparam int H0 = (c < N) ? c + 1 : ((c < W - 1) ? W - 1 - c : 0);
    localparam int I0 = (c < N) ? 0 : c - N + 1;
    for (genvar k = 0; k < HMAX; k++) begin : g_pos
      if (k < H0) begin : g_and
        assign cols[c][k] = op_a[I0 + k] & op_b[c - I0 - k];
      end else begin : g_nil
        assign cols[c][k] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/wtm_fa.sv
module wtm_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  logic xy;
  assign xy = x ^ y;
  assign s  = xy ^ z;
  assign co = (x & y) | (z & xy);
endmodule

// File: rtl/wtm_stage.sv
module wtm_stage
  import wtm_pkg::*;
#(
  parameter int N    = 8,
  parameter int S    = 0,
  parameter int W    = 2 * N,
  parameter int HMAX = N
) (
  input  logic [W-1:0][HMAX-1:0] col_i,
  output logic [W-1:0][HMAX-1:0] col_o
);

  logic [W-1:0][HMAX-1:0] cy;

  for (genvar c = 0; c < W; c++) begin : g_col
    localparam int H   = wt_info(N, S, c, 0);
    localparam int FA  = H / 3;
    localparam int REM = H % 3;
    localparam int HA  = wt_info(N, S, c, 1);
    localparam int CIN = wt_info(N, S, c - 1, 0) / 3 + wt_info(N, S, c - 1, 1);
    localparam int PB  = FA + ((HA != 0) ? 1 : REM);
    localparam int NO  = PB + CIN;
    localparam int NC  = FA + HA;

    for (genvar g = 0; g < FA; g++) begin : g_fa
      wtm_fa u_fa (
        .x  (col_i[c][3*g]),
        .y  (col_i[c][3*g+1]),
        .z  (col_i[c][3*g+2]),
        .s  (col_o[c][g]),
        .co (cy[c][g])
      );
    end

    if (HA != 0) begin : g_ha
      assign col_o[c][FA] = col_i[c][3*FA] ^ col_i[c][3*FA+1];
      assign cy[c][FA]    = col_i[c][3*FA] & col_i[c][3*FA+1];
    end else begin : g_pass
      for (genvar r = 0; r < REM; r++) begin : g_bit
        assign col_o[c][FA+r] = col_i[c][3*FA+r];
      end
    end

    for (genvar j = 0; j < CIN; j++) begin : g_cin
      assign col_o[c][PB+j] = cy[c-1][j];
    end

    if (NO < HMAX) begin : g_opad
      assign col_o[c][HMAX-1:NO] = '0;
    end
    if (NC < HMAX) begin : g_cpad
      assign cy[c][HMAX-1:NC] = '0;
    end
  end

endmodule

// File: rtl/wtm_reduce.sv
module wtm_reduce
  import wtm_pkg::*;
#(
  parameter int N    = 8,
  parameter int W    = 2 * N,
  parameter int HMAX = N
) (
  input  logic [W-1:0][HMAX-1:0] cols,
  output logic [W-1:0]           row0,
  output logic [W-1:0]           row1
);

  localparam int NS = wt_stages(N);

  logic [W-1:0][HMAX-1:0] mat [NS+1];

  assign mat[0] = cols;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    wtm_stage #(.N(N), .S(s), .W(W), .HMAX(HMAX)) u_stage (
      .col_i (mat[s]),
      .col_o (mat[s+1])
    );
  end

  for (genvar c = 0; c < W; c++) begin : g_row
    assign row0[c] = mat[NS][c][0];
    assign row1[c] = mat[NS][c][1];
  end

endmodule

// File: rtl/wtm_cla.sv
module wtm_cla
  import wtm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);

  localparam int NB = (W + 3) / 4;
  localparam int WP = NB * 4;

  logic [WP-1:0] xp, yp, g, p, c;
  logic [NB:0]   bc;

  assign xp    = WP'(x);
  assign yp    = WP'(y);
  assign g     = xp & yp;
  assign p     = xp ^ yp;
  assign bc[0] = 1'b0;

  for (genvar b = 0; b < NB; b++) begin : g_blk
    logic [3:0] gb, pb;
    assign gb = g[4*b +: 4];
    assign pb = p[4*b +: 4];
    for (genvar i = 0; i <= 4; i++) begin : g_pos
      logic [4:0] t;
      assign t[0] = bc[b] & (&(pb | ~grp_mask(0, i)));
      for (genvar j = 0; j < 4; j++) begin : g_term
        if (j < i) begin : g_on
          assign t[j+1] = gb[j] & (&(pb | ~grp_mask(j + 1, i)));
        end else begin : g_off
          assign t[j+1] = 1'b0;
        end
      end
      if (i < 4) begin : g_bit
        assign c[4*b+i] = |t;
      end else begin : g_out
        assign bc[b+1] = |t;
      end
    end
  end

  logic [WP-1:0] sp;
  assign sp  = p ^ c;
  assign sum = sp[W-1:0];

endmodule

// File: rtl/wtm_mult.sv
module wtm_mult
  import wtm_pkg::*;
#(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod
);

  localparam int W    = 2 * N;
  localparam int HMAX = wt_hmax(N);

  logic [W-1:0][HMAX-1:0] cols;
  logic [W-1:0]           row0, row1, sum_c;

  wtm_ppgen #(.N(N), .W(W), .HMAX(HMAX)) u_pp (
    .op_a (op_a),
    .op_b (op_b),
    .cols (cols)
  );

  wtm_reduce #(.N(N), .W(W), .HMAX(HMAX)) u_red (
    .cols (cols),
    .row0 (row0),
    .row1 (row1)
  );

  wtm_cla #(.W(W)) u_cla (
    .x   (row0),
    .y   (row1),
    .sum (sum_c)
  );

  if (OUT_REG) begin : g_reg
    logic [W-1:0] prod_q;
    always_ff @(posedge clk) begin
      if (rst) prod_q <= '0;
      else     prod_q <= sum_c;
    end
    assign prod = prod_q;
  end else begin : g_comb
    assign prod = sum_c;
  end

endmodule

// File: rtl/wtm_mult_chk.sv
module wtm_mult_chk #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic [2*N-1:0] prod
);

  localparam int W = 2 * N;
  localparam logic [W-1:0] PMAX = W'({N{1'b1}}) * W'({N{1'b1}});

  logic [N-1:0] ra, rb;
  logic         live;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) live <= 1'b0;
      else     live <= 1'b1;
      ra <= op_a;
      rb <= op_b;
    end
  end else begin : g_comb
    assign live = ~rst;
    assign ra   = op_a;
    assign rb   = op_b;
  end

  // R1 / R2 / R7: full-width exact product
  a_r1_exact_product: assert property (@(posedge clk) disable iff (rst)
    live |-> prod == W'(ra) * W'(rb));

  a_r3_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (live && ((ra == '0) || (rb == '0))) |-> prod == '0);

  a_r4_unit_operand: assert property (@(posedge clk) disable iff (rst)
    (live && (ra == N'(1))) |-> prod == W'(rb));

  a_r5_all_ones: assert property (@(posedge clk) disable iff (rst)
    (live && (&ra) && (&rb)) |-> prod == PMAX);

  a_r8_single_weight: assert property (@(posedge clk) disable iff (rst)
    (live && ($countones(ra) == 1) && ($countones(rb) == 1)) |-> $countones(prod) == 1);

  if (OUT_REG) begin : g_hold
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
      (live && $stable(op_a) && $stable(op_b)) |=> $stable(prod));
  end

endmodule

bind wtm_mult wtm_mult_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .op_a (op_a),
  .op_b (op_b),
  .prod (prod)
);

// File: tb/tb_wtm_mult.sv
`timescale 1ns/1ps
module tb_wtm_mult;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [15:0] p8;
  logic [7:0]  p4;
  logic [15:0] prev8;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  wtm_mult #(.N(8), .OUT_REG(1'b1)) dut (
    .clk (clk), .rst (rst), .op_a (a8), .op_b (b8), .prod (p8)
  );

  wtm_mult #(.N(4), .OUT_REG(1'b0)) dut_n4 (
    .clk (clk), .rst (rst), .op_a (a4), .op_b (b4), .prod (p4)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // Drives both multipliers; checks N=4 same cycle (R7), N=8 hold (R6) and after one edge.
  task automatic step(input string tag, input logic [7:0] x8, input logic [7:0] y8,
                      input logic [3:0] x4, input logic [3:0] y4);
    @(negedge clk);
    a8 = x8; b8 = y8; a4 = x4; b4 = y4;
    #1;
    chk({tag, "/R7 n4"}, {8'h00, p4}, 16'(x4) * 16'(y4));
    chk("R6 hold before edge", p8, prev8);
    @(posedge clk);
    #1;
    prev8 = 16'(x8) * 16'(y8);
    chk({tag, " n8"}, p8, prev8);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a8 = 8'h37; b8 = 8'h05;
    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset clears", p8, 16'h0000);
    @(negedge clk);
    rst   = 1'b0;
    prev8 = 16'(8'h37) * 16'(8'h05);
    @(posedge clk);
    #1;
    chk("R6 first capture", p8, prev8);

    step("R3 zero a", 8'h00, 8'hC3, 4'h0, 4'h9);
    step("R3 zero b", 8'h5A, 8'h00, 4'h7, 4'h0);
    step("R4 one", 8'h01, 8'hB7, 4'h1, 4'hD);
    step("R4 one max", 8'h01, 8'hFF, 4'h1, 4'hF);
    step("R5 all ones", 8'hFF, 8'hFF, 4'hF, 4'hF);
    step("R1 alt bits", 8'hAA, 8'h55, 4'hA, 4'h5);
    step("R1 high bits", 8'h80, 8'hFF, 4'h8, 4'hF);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        step("R8 weight", 8'(1 << i), 8'(1 << j), 4'(1 << (i % 4)), 4'(1 << (j % 4)));
      end
    end

    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        step("R2 sweep", {4'(x), 4'(y)}, {4'(y), 4'(x)}, 4'(x), 4'(y));
      end
    end

    for (int k = 0; k < 10000; k++) begin
      step("R1 random", 8'($urandom), 8'($urandom), 4'($urandom), 4'($urandom));
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R6 reset after run", p8, 16'h0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule